// File: doc/BRIEF.md
# H-Bridge Chopping Decay Controller

This block runs fixed-frequency current chopping for one phase of a bipolar motor. An external oscillator supplies a period tick, and an external comparator reports whether the coil current has reached the set-point. The block then drives the four gate enables of one H-bridge through charge, slow decay and fast decay. Each period starts with a forced-charge blanking window. What the comparator reported during that window picks the decay policy. A fast-decay tail always closes the period. Every change between drive states is separated by an all-off interval, so a high-side and a low-side switch on the same leg never conduct together.

The parameters set all timings in clock cycles: the nominal period, the blanking length, the fast-decay tail and the dead time. The tick is expected once every `PERIOD_CYC` cycles. For a 40 to 125 kHz chop rate, the tick spacing is set to match. The polarity input sets which bridge diagonal carries current. It is taken only when a period starts.

Top module: `chop_decay_ctrl`

## Requirements
- R1: After reset the gates are all off, and they stay off until the first period tick arrives while the block is enabled.
- R2: A tick (sampled at a clock edge, block enabled) starts charge. The gates show charge on the next cycle when coming from all-off. Coming from any other drive state, they show charge after the R7 dead interval. For BLANK_CYC cycles after the tick the comparator cannot end charge.
- R3: If the comparator reads below set-point in any cycle of the blanking window, charge continues until it reads at/above set-point after blanking. The block then enters slow decay.
- R4: From position PERIOD_CYC-FAST_CYC (counted in cycles from the tick) until the next tick, the target state is fast decay, whether the block was in charge or in slow decay.
- R5: If the comparator reads at/above set-point throughout blanking, the block goes straight from charge to fast decay when blanking ends.
- R6: gate_o bit 3 = high-side A, bit 2 = high-side B, bit 1 = low-side A, bit 0 = low-side B. With dir_i=0 (A to B): charge 1001, slow 0011, fast 0110. With dir_i=1 (B to A): charge 0110, slow 0011, fast 1001.
- R7: A decided change of state reaches the gates one cycle later as DEAD_CYC all-off cycles, followed by the new pattern. A polarity change counts as a change of state. High and low side of the same leg are never on together.
- R8: dir_i is sampled only at a period tick. Changes during a period do not alter the gates.
- R9: When en_i is low or fault_i is high, all gates are off in the same cycle. Ticks are ignored during that time. After recovery the gates stay off until the next tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Drive enable, active high |
| fault_i | input | 1 | Fault, forces all gates off |
| tick_i | input | 1 | One-cycle chop period start |
| above_i | input | 1 | Comparator: coil current at or above set-point |
| dir_i | input | 1 | Current polarity: 0 A to B, 1 B to A |
| gate_o | output | 4 | Gate enables {high A, high B, low A, low B} |

## Verification
The comparator is driven with four shapes: low through part of the period and then high, high all the time, high with a one-cycle dip inside blanking, and low for the whole period. The first and third give the slow-decay path. The second gives the direct fast path, and the third shows that a single low reading inside blanking is enough to pick that policy. The fourth shows that the fast tail preempts a charge that never reaches the set-point. Periods are run with both polarities, with the polarity flipped mid-period, and back to back, so that the dead interval is observed both entering and leaving every state. The enable and fault inputs are dropped in the middle of a period to show the same-cycle shutdown and the wait for a fresh tick.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;

  typedef enum logic [1:0] {
    MODE_OFF,
    MODE_CHARGE,
    MODE_SLOW,
    MODE_FAST
  } chop_mode_e;

  // gate order {hs_a, hs_b, ls_a, ls_b}; rev=1 means B to A
  function automatic logic [3:0] gate_pattern(chop_mode_e m, logic rev);
    logic [3:0] p;
    unique case (m)
      MODE_CHARGE: p = rev ? 4'b0110 : 4'b1001;
      MODE_SLOW:   p = 4'b0011;
      MODE_FAST:   p = rev ? 4'b1001 : 4'b0110;
      default:     p = 4'b0000;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/chop_period_ctr.sv
`timescale 1ns/1ps
module chop_period_ctr #(
  parameter int PERIOD_CYC = 40,
  parameter int PW         = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  output logic [PW-1:0] pos_o
);

  localparam logic [PW-1:0] POS_MAX = PW'(PERIOD_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pos_o <= '0;
    else if (tick_i)          pos_o <= '0;
    else if (pos_o != POS_MAX) pos_o <= pos_o + 1'b1;
  end

endmodule

// File: rtl/chop_mode_seq.sv
`timescale 1ns/1ps
module chop_mode_seq
  import chop_pkg::*;
#(
  parameter int PW         = 6,
  parameter int BLANK_CYC  = 8,
  parameter int FAST_START = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic          above_i,
  input  logic          dir_i,
  input  logic [PW-1:0] pos_i,
  output chop_mode_e    mode_o,
  output logic          rev_o
);

  localparam logic [PW-1:0] BLANK_POS = PW'(BLANK_CYC);
  localparam logic [PW-1:0] FAST_POS  = PW'(FAST_START);

  logic low_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_OFF;
      rev_o      <= 1'b0;
      low_seen_q <= 1'b0;
    end else if (!run_i) begin
      mode_o     <= MODE_OFF;
    end else if (tick_i) begin
      mode_o     <= MODE_CHARGE;
      rev_o      <= dir_i;
      low_seen_q <= 1'b0;
    end else begin
      unique case (mode_o)
        MODE_CHARGE: begin
          if (pos_i < BLANK_POS) begin
            if (!above_i) low_seen_q <= 1'b1;
          end else if (pos_i >= FAST_POS || !low_seen_q) begin
            mode_o <= MODE_FAST;
          end else if (above_i) begin
            mode_o <= MODE_SLOW;
          end
        end
        MODE_SLOW: if (pos_i >= FAST_POS) mode_o <= MODE_FAST;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/chop_gate_drv.sv
`timescale 1ns/1ps
module chop_gate_drv
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  chop_mode_e mode_i,
  input  logic       rev_i,
  output logic [3:0] gate_o
);

  localparam int CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;

  chop_mode_e app_mode_q;
  logic       app_rev_q;

  generate
    if (DEAD_CYC == 0) begin : g_no_dead
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          app_mode_q <= MODE_OFF;
          app_rev_q  <= 1'b0;
        end else if (!run_i) begin
          app_mode_q <= MODE_OFF;
        end else begin
          app_mode_q <= mode_i;
          app_rev_q  <= rev_i;
        end
      end
      assign gate_o = run_i ? gate_pattern(app_mode_q, app_rev_q) : 4'b0000;
    end else begin : g_dead
      logic          dead_q;
      logic [CW-1:0] cnt_q;
      logic          change;

      assign change = (mode_i != app_mode_q) || (rev_i != app_rev_q);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          app_mode_q <= MODE_OFF;
          app_rev_q  <= 1'b0;
          dead_q     <= 1'b0;
          cnt_q      <= '0;
        end else if (!run_i) begin
          app_mode_q <= MODE_OFF;
          dead_q     <= 1'b0;
        end else if (dead_q) begin
          if (cnt_q == '0) begin
            dead_q     <= 1'b0;
            app_mode_q <= mode_i;
            app_rev_q  <= rev_i;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end else if (change) begin
          // from or to all-off there is nothing to break
          if (app_mode_q == MODE_OFF || mode_i == MODE_OFF) begin
            app_mode_q <= mode_i;
            app_rev_q  <= rev_i;
          end else begin
            dead_q <= 1'b1;
            cnt_q  <= CW'(DEAD_CYC - 1);
          end
        end
      end

      assign gate_o = (run_i && !dead_q) ? gate_pattern(app_mode_q, app_rev_q) : 4'b0000;
    end
  endgenerate

endmodule

// File: rtl/chop_decay_ctrl.sv
`timescale 1ns/1ps
module chop_decay_ctrl
  import chop_pkg::*;
#(
  parameter int PERIOD_CYC = 40,
  parameter int BLANK_CYC  = 8,
  parameter int FAST_CYC   = 8,
  parameter int DEAD_CYC   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fault_i,
  input  logic       tick_i,
  input  logic       above_i,
  input  logic       dir_i,
  output logic [3:0] gate_o
);

  localparam int PW         = $clog2(PERIOD_CYC + 1);
  localparam int FAST_START = PERIOD_CYC - FAST_CYC;

  logic          run;
  logic [PW-1:0] pos;
  chop_mode_e    seq_mode;
  logic          seq_rev;

  assign run = en_i && !fault_i;

  chop_period_ctr #(.PERIOD_CYC(PERIOD_CYC), .PW(PW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .pos_o  (pos)
  );

  chop_mode_seq #(.PW(PW), .BLANK_CYC(BLANK_CYC), .FAST_START(FAST_START)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .tick_i  (tick_i),
    .above_i (above_i),
    .dir_i   (dir_i),
    .pos_i   (pos),
    .mode_o  (seq_mode),
    .rev_o   (seq_rev)
  );

  chop_gate_drv #(.DEAD_CYC(DEAD_CYC)) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mode_i (seq_mode),
    .rev_i  (seq_rev),
    .gate_o (gate_o)
  );

endmodule

// File: rtl/chop_decay_ctrl_chk.sv
`timescale 1ns/1ps
module chop_decay_ctrl_chk
  import chop_pkg::*;
#(
  parameter int PW         = 6,
  parameter int BLANK_CYC  = 8,
  parameter int FAST_START = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          fault_i,
  input logic          tick_i,
  input logic [3:0]    gate_o,
  input chop_mode_e    mode_i,
  input logic          rev_i,
  input logic [PW-1:0] pos_i
);

  localparam logic [PW-1:0] BLANK_POS = PW'(BLANK_CYC);
  localparam logic [PW-1:0] FAST_POS  = PW'(FAST_START);

  // R9
  off_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || fault_i) |-> gate_o == 4'b0000);

  // R7
  no_shoot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gate_o[3] && gate_o[1]) && !(gate_o[2] && gate_o[0]));

  // R7
  dead_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o != 4'b0000 && $past(gate_o) != 4'b0000) |-> gate_o == $past(gate_o));

  // R2
  blank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fault_i && !tick_i && mode_i == MODE_CHARGE && pos_i < BLANK_POS)
      |=> mode_i == MODE_CHARGE);

  // R4
  fast_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !fault_i && !tick_i && mode_i != MODE_OFF && pos_i >= FAST_POS)
      |=> mode_i == MODE_FAST);

  // R8
  dir_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && en_i && !fault_i) |=> $stable(rev_i));

endmodule

bind chop_decay_ctrl chop_decay_ctrl_chk #(
  .PW(PW), .BLANK_CYC(BLANK_CYC), .FAST_START(FAST_START)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .fault_i (fault_i),
  .tick_i  (tick_i),
  .gate_o  (gate_o),
  .mode_i  (seq_mode),
  .rev_i   (seq_rev),
  .pos_i   (pos)
);

// File: tb/chop_decay_ctrl_bench.sv
`timescale 1ns/1ps
module chop_decay_ctrl_bench;

  localparam int PER = 40;
  localparam int BL  = 8;
  localparam int FC  = 8;
  localparam int DC  = 2;
  localparam int FS  = PER - FC;

  localparam logic [3:0] OFF  = 4'b0000;
  localparam logic [3:0] C_AB = 4'b1001;
  localparam logic [3:0] F_AB = 4'b0110;
  localparam logic [3:0] C_BA = 4'b0110;
  localparam logic [3:0] F_BA = 4'b1001;
  localparam logic [3:0] SLW  = 4'b0011;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b1, fault = 1'b0, tick = 1'b0, above = 1'b0, dir = 1'b0;
  logic [3:0] gate;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [3:0] g [PER];

  always #2 clk = ~clk;

  chop_decay_ctrl #(.PERIOD_CYC(PER), .BLANK_CYC(BL), .FAST_CYC(FC), .DEAD_CYC(DC)) u_chop_decay_ctrl (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .fault_i (fault),
    .tick_i  (tick),
    .above_i (above),
    .dir_i   (dir),
    .gate_o  (gate)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: gate_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_span(input string req, input int a, input int b, input logic [3:0] exp);
    for (int k = a; k <= b; k++) chk($sformatf("%s k=%0d", req, k), g[k], exp);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic above_at(input int sc, input int k);
    case (sc)
      0: return (k >= 12);
      1: return 1'b1;
      2: return (k != 4);
      default: return 1'b0;
    endcase
  endfunction

  // tick lands on edge E0; g[k] is the gate value after edge Ek
  task automatic run_period(input int sc, input int flip_at);
    tick = 1'b1;
    step();
    tick = 1'b0;
    above = above_at(sc, 0);
    for (int k = 1; k < PER; k++) begin
      step();
      g[k] = gate;
      above = above_at(sc, k);
      if (k == flip_at) dir = ~dir;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) step();
    rst_ni = 1'b1;
    repeat (4) begin
      step();
      chk("R1 idle before first tick", gate, OFF);
    end
  endtask

  task automatic t_mixed_from_off();
    run_period(0, -1);
    chk_span("R2 charge from off", 1, 13, C_AB);
    chk_span("R7 gap charge-slow", 14, 13 + DC, OFF);
    chk_span("R3 slow after set-point", 14 + DC, FS + 1, SLW);
    chk_span("R7 gap slow-fast", FS + 2, FS + 1 + DC, OFF);
    chk_span("R4 fast tail", FS + 2 + DC, PER - 1, F_AB);
  endtask

  task automatic t_fast_path();
    run_period(1, -1);
    chk_span("R7 gap fast-charge", 1, DC, OFF);
    chk_span("R2 blanking holds charge", DC + 1, BL + 1, C_AB);
    chk_span("R7 gap charge-fast", BL + 2, BL + 1 + DC, OFF);
    chk_span("R5 direct fast", BL + 2 + DC, PER - 1, F_AB);
  endtask

  task automatic t_dip_in_blank();
    run_period(2, -1);
    chk_span("R2 charge", DC + 1, BL + 1, C_AB);
    chk_span("R7 gap", BL + 2, BL + 1 + DC, OFF);
    chk_span("R3 dip selects slow", BL + 2 + DC, FS + 1, SLW);
    chk_span("R4 fast tail", FS + 2 + DC, PER - 1, F_AB);
  endtask

  task automatic t_never_reached();
    run_period(3, 20);
    chk_span("R4 charge held to tail", DC + 1, 20, C_AB);
    chk_span("R8 mid-period dir flip ignored", 21, FS + 1, C_AB);
    chk_span("R7 gap charge-fast", FS + 2, FS + 1 + DC, OFF);
    chk_span("R8 tail keeps old polarity", FS + 2 + DC, PER - 1, F_AB);
  endtask

  task automatic t_reverse();
    run_period(0, -1);
    chk_span("R7 gap on polarity change", 1, DC, OFF);
    chk_span("R6 charge B to A", DC + 1, 13, C_BA);
    chk_span("R6 slow B to A", 14 + DC, FS + 1, SLW);
    chk_span("R6 fast B to A", FS + 2 + DC, PER - 1, F_BA);
  endtask

  task automatic t_disable();
    tick = 1'b1;
    step();
    tick = 1'b0;
    above = 1'b1;
    repeat (20) step();
    chk("R9 drive before disable", gate, F_BA);
    en = 1'b0;
    #1;
    chk("R9 same-cycle off on enable low", gate, OFF);
    tick = 1'b1;
    step();
    tick = 1'b0;
    repeat (5) begin
      step();
      chk("R9 tick ignored while disabled", gate, OFF);
    end
    en = 1'b1;
    repeat (6) begin
      step();
      chk("R9 stays off until tick", gate, OFF);
    end
    tick = 1'b1;
    step();
    tick = 1'b0;
    step();
    chk("R9 restart charge on tick", gate, C_BA);
    repeat (3) step();
  endtask

  task automatic t_fault();
    chk("R9 charging before fault", gate, C_BA);
    fault = 1'b1;
    #1;
    chk("R9 same-cycle off on fault", gate, OFF);
    step();
    chk("R9 held off in fault", gate, OFF);
    fault = 1'b0;
    #1;
    chk("R9 off after fault clears", gate, OFF);
    repeat (4) begin
      step();
      chk("R9 no drive without tick", gate, OFF);
    end
    dir = 1'b0;
    tick = 1'b1;
    step();
    tick = 1'b0;
    step();
    chk("R9 R6 restart A to B", gate, C_AB);
  endtask

  initial begin
    #1;
    t_reset();
    t_mixed_from_off();
    t_fast_path();
    t_dip_in_blank();
    t_never_reached();
    t_reverse();
    t_disable();
    t_fault();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule